// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical position counters of a raster display and derives from them blanking, display-enable, a pair of monitor-style sync pulses and a second pair of sync pulses meant for a flat panel. Every timing point comes from a small register file. Software writes that file over a plain 32-bit address/data bus. Each horizontal and vertical register holds two fields, and each field is a position minus one.

The register file is guarded by a key. Timing and control writes only land after the key word has been written to the key register. Writing zero to the key register closes the file again. The panel vertical sync has its own register pair. Software usually programs it one line ahead of the monitor vertical sync. A control register holds the master run bit, the blank enable and separate enables for each sync group. Clearing the run bit parks both counters at zero and silences every output.

Top module: `dtg_top`

## Requirements
- R1: After reset the file is locked, every register reads 0, both counters are 0 and every output is low.
- R2: Writing UNLOCK_KEY to address 0 unlocks the file, and address 0 then reads 1. Writing 0 to address 0 locks it, and address 0 then reads 0. Any other value written there leaves the lock unchanged.
- R3: While the file is locked, writes to addresses 1 to 9 are ignored. Reads at any time return the stored value. Reads at unmapped addresses return 0.
- R4: Map: 1 control, 2 h active/total, 3 h blank start/end, 4 h sync start/end, 5 v active/total, 6 v blank start/end, 7 v sync start/end, 8 panel h sync start/end, 9 panel v sync start/end. In each pair the first field sits in bits CW-1:0 and the second in bits 16+CW-1:16. Each field is the real position minus one.
- R5: While running, the horizontal counter counts 0 up to the total field and then returns to 0. Each wrap advances the vertical counter, which returns to 0 after it reaches its own total field.
- R6: Control bit 0 is run. While run is 0, both counters go to 0 on the next clock and every output is low.
- R7: A position p is in blanking when start < p <= end, using the stored blank fields. de is high when run is high, blank enable is high, h <= h active field, v <= v active field, and neither axis is in blanking.
- R8: Control bit 1 is blank enable. While it is 0, de stays low.
- R9: hsync is high when run and control bit 2 are both set and start < h <= end, using the h sync fields. vsync follows the same rule with control bit 3 and the v sync fields. Both are active high.
- R10: The panel syncs use registers 8 and 9 with the same window rule, gated by run and control bit 4. pnl_de is de gated by control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| h_count | output | CW | Horizontal position |
| v_count | output | CW | Vertical position |
| de | output | 1 | Display enable |
| hsync | output | 1 | Monitor horizontal sync |
| vsync | output | 1 | Monitor vertical sync |
| pnl_hsync | output | 1 | Panel horizontal sync |
| pnl_vsync | output | 1 | Panel vertical sync |
| pnl_de | output | 1 | Panel data enable |

## Verification
The hardest case to reach is a write that arrives while the file is locked, after a valid raster is already programmed and running. To get there, the stimulus unlocks the file, programs the raster and runs a full frame, then relocks it. Next it writes conflicting timing values, which it observes both by reading back and by sweeping further frames whose every output must still match the old timing. A wrong key and a stopped raster are checked in the same way at the ports. Every output is compared against an arithmetic model on every cycle of whole frames, in several enable combinations.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam int NREG     = 10;
   localparam int ADR_KEY  = 0;
   localparam int ADR_CTRL = 1;
   localparam int ADR_HAT  = 2;
   localparam int ADR_HBL  = 3;
   localparam int ADR_HSY  = 4;
   localparam int ADR_VAT  = 5;
   localparam int ADR_VBL  = 6;
   localparam int ADR_VSY  = 7;
   localparam int ADR_PHS  = 8;
   localparam int ADR_PVS  = 9;

   localparam int CB_RUN   = 0;
   localparam int CB_BLANK = 1;
   localparam int CB_HS    = 2;
   localparam int CB_VS    = 3;
   localparam int CB_PNL   = 4;

   localparam int NWIN     = 6;

   // window order: h blank, h sync, panel h, v blank, v sync, panel v
   function automatic int win_addr(input int w);
      case (w)
         0: return ADR_HBL;
         1: return ADR_HSY;
         2: return ADR_PHS;
         3: return ADR_VBL;
         4: return ADR_VSY;
         default: return ADR_PVS;
      endcase
   endfunction
endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile
   import dtg_pkg::*;
#(
   parameter int          AW         = 4,
   parameter logic [31:0] UNLOCK_KEY = 32'h5A17_C0DE
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [AW-1:0]              addr,
   input  logic [31:0]                wdata,
   output logic [31:0]                rdata,
   output logic                       unlocked,
   output logic [NREG-1:0][31:0]      regs
);
   localparam int DEPTH = 1 << AW;

   if (DEPTH < NREG) begin : g_bad_aw
      $error("dtg_regfile: AW too small for the register map");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         unlocked <= 1'b0;
      else if (we && addr == AW'(ADR_KEY)) begin
         if (wdata == UNLOCK_KEY)
            unlocked <= 1'b1;
         else if (wdata == 32'd0)
            unlocked <= 1'b0;
      end
   end

   assign regs[0] = '0;

   for (genvar g = 1; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (we && unlocked && addr == AW'(g))
            regs[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(ADR_KEY))
         rdata = {31'd0, unlocked};
      else if (int'(addr) < NREG)
         rdata = regs[addr];
   end
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster #(
   parameter int CW = 12
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] htot,
   input  logic [CW-1:0] vtot,
   output logic [CW-1:0] h,
   output logic [CW-1:0] v
);
   logic h_wrap, v_wrap;

   assign h_wrap = (h >= htot);
   assign v_wrap = (v >= vtot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h <= '0;
         v <= '0;
      end else if (!run) begin
         h <= '0;
         v <= '0;
      end else if (h_wrap) begin
         h <= '0;
         v <= v_wrap ? '0 : v + 1'b1;
      end else begin
         h <= h + 1'b1;
      end
   end
endmodule

// File: rtl/dtg_window.sv
module dtg_window #(
   parameter int CW = 12
)(
   input  logic [CW-1:0] pos,
   input  logic [CW-1:0] lo,
   input  logic [CW-1:0] hi,
   output logic          hit
);
   // fields hold position minus one: inside when lo < pos <= hi
   assign hit = (pos > lo) && (pos <= hi);
endmodule

// File: rtl/dtg_top.sv
module dtg_top
   import dtg_pkg::*;
#(
   parameter int          CW         = 12,
   parameter int          AW         = 4,
   parameter logic [31:0] UNLOCK_KEY = 32'h5A17_C0DE
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic [CW-1:0] h_count,
   output logic [CW-1:0] v_count,
   output logic          de,
   output logic          hsync,
   output logic          vsync,
   output logic          pnl_hsync,
   output logic          pnl_vsync,
   output logic          pnl_de
);
   localparam int HI_LSB = 16;

   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("dtg_top: CW must lie in 2..16");
   end

   logic                  unlocked;
   logic [NREG-1:0][31:0] regs;
   logic [CW-1:0]         hact, htot, vact, vtot;
   logic [NWIN-1:0]       win;
   logic                  run, blank_en, hs_en, vs_en, pnl_en;

   dtg_regfile #(.AW(AW), .UNLOCK_KEY(UNLOCK_KEY)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .unlocked(unlocked), .regs(regs)
   );

   assign run      = regs[ADR_CTRL][CB_RUN];
   assign blank_en = regs[ADR_CTRL][CB_BLANK];
   assign hs_en    = regs[ADR_CTRL][CB_HS];
   assign vs_en    = regs[ADR_CTRL][CB_VS];
   assign pnl_en   = regs[ADR_CTRL][CB_PNL];

   assign hact = regs[ADR_HAT][CW-1:0];
   assign htot = regs[ADR_HAT][HI_LSB +: CW];
   assign vact = regs[ADR_VAT][CW-1:0];
   assign vtot = regs[ADR_VAT][HI_LSB +: CW];

   dtg_raster #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .htot(htot), .vtot(vtot),
      .h(h_count), .v(v_count)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam int A = win_addr(w);
      dtg_window #(.CW(CW)) u_w (
         .pos((w < NWIN/2) ? h_count : v_count),
         .lo (regs[A][CW-1:0]),
         .hi (regs[A][HI_LSB +: CW]),
         .hit(win[w])
      );
   end

   logic in_active;
   assign in_active = (h_count <= hact) && (v_count <= vact) && !win[0] && !win[3];

   assign de        = run && blank_en && in_active;
   assign hsync     = run && hs_en  && win[1];
   assign vsync     = run && vs_en  && win[4];
   assign pnl_hsync = run && pnl_en && win[2];
   assign pnl_vsync = run && pnl_en && win[5];
   assign pnl_de    = pnl_en && de;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
   import dtg_pkg::*;
#(
   parameter int CW = 12,
   parameter int AW = 4
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_we,
   input logic [AW-1:0]         bus_addr,
   input logic [31:0]           bus_wdata,
   input logic                  unlocked,
   input logic [NREG-1:0][31:0] regs,
   input logic                  run,
   input logic                  blank_en,
   input logic [CW-1:0]         htot,
   input logic [CW-1:0]         vtot,
   input logic [CW-1:0]         h_count,
   input logic [CW-1:0]         v_count,
   input logic                  de,
   input logic                  hsync,
   input logic                  vsync,
   input logic                  pnl_hsync,
   input logic                  pnl_vsync
);
   p_relock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == AW'(ADR_KEY) && bus_wdata == 32'd0 |=> !unlocked);

   p_locked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked && bus_we && bus_addr != AW'(ADR_KEY) |=> $stable(regs));

   p_hwrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run && h_count >= htot |=> h_count == '0);

   p_vstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run && h_count >= htot && v_count < vtot |=> v_count == $past(v_count) + 1'b1);

   p_hstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && h_count != '0 |-> h_count == $past(h_count) + 1'b1);

   p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> h_count == '0 && v_count == '0);

   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !de && !hsync && !vsync && !pnl_hsync && !pnl_vsync);

   p_noblank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_en |-> !de);
endmodule

bind dtg_top dtg_checker #(.CW(CW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .unlocked(unlocked), .regs(regs), .run(run),
   .blank_en(blank_en), .htot(htot), .vtot(vtot), .h_count(h_count),
   .v_count(v_count), .de(de), .hsync(hsync), .vsync(vsync),
   .pnl_hsync(pnl_hsync), .pnl_vsync(pnl_vsync)
);

// File: tb/sim_dtg_top.sv
`timescale 1ns/1ps
module sim_dtg_top;
   localparam int          CW  = 12;
   localparam int          AW  = 4;
   localparam logic [31:0] KEY = 32'h5A17_C0DE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [CW-1:0] h_count, v_count;
   logic          de, hsync, vsync, pnl_hsync, pnl_vsync, pnl_de;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   // real raster: positions, intervals are [start, end)
   int HA = 6, HT = 10, HBS = 6, HSS = 7, HSE = 9;
   int VA = 4, VT = 7,  VBS = 4, VSS = 5, VSE = 6;
   int PVS = 4, PVE = 5;

   always #5 clk = ~clk;

   dtg_top #(.CW(CW), .AW(AW), .UNLOCK_KEY(KEY)) u0 (.*);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<=100000 cycles", cycles);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] pack2(input int first, input int second);
      return (32'(second - 1) << 16) | 32'(first - 1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = AW'(a);
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic program_all();
      wr(2, pack2(HA, HT));
      wr(3, pack2(HBS, HT));
      wr(4, pack2(HSS, HSE));
      wr(5, pack2(VA, VT));
      wr(6, pack2(VBS, VT));
      wr(7, pack2(VSS, VSE));
      wr(8, pack2(HSS, HSE));
      wr(9, pack2(PVS, PVE));
   endtask

   // start raster with ctrl (bit0 set) and compare every cycle for nframes
   task automatic sweep(input logic [4:0] ctrl, input int nframes);
      int hm = 0, vm = 0;
      bit eb, ehs, evs, eph, epv, ede;
      wr(1, 32'd0);
      wr(1, {27'd0, ctrl});
      for (int c = 0; c < nframes * HT * VT; c++) begin
         eb  = (hm >= HBS) || (vm >= VBS);
         ede = ctrl[1] && hm < HA && vm < VA && !eb;
         ehs = ctrl[2] && hm >= HSS && hm < HSE;
         evs = ctrl[3] && vm >= VSS && vm < VSE;
         eph = ctrl[4] && hm >= HSS && hm < HSE;
         epv = ctrl[4] && vm >= PVS && vm < PVE;
         chk("R5 h_count", 32'(h_count), 32'(hm));
         chk("R5 v_count", 32'(v_count), 32'(vm));
         chk("R7 R8 de", 32'(de), 32'(ede));
         chk("R9 hsync", 32'(hsync), 32'(ehs));
         chk("R9 vsync", 32'(vsync), 32'(evs));
         chk("R10 pnl_hsync", 32'(pnl_hsync), 32'(eph));
         chk("R10 pnl_vsync", 32'(pnl_vsync), 32'(epv));
         chk("R10 pnl_de", 32'(pnl_de), 32'(ctrl[4] && ede));
         @(negedge clk);
         if (hm == HT - 1) begin
            hm = 0;
            vm = (vm == VT - 1) ? 0 : vm + 1;
         end else hm++;
      end
   endtask

   initial begin
      #22 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 h_count", 32'(h_count), 0);
      chk("R1 v_count", 32'(v_count), 0);
      chk("R1 outputs", 32'({de, hsync, vsync, pnl_hsync, pnl_vsync, pnl_de}), 0);
      for (int a = 0; a < 10; a++) rd_chk("R1 reg reset", a, 0);

      // R3 locked writes ignored
      wr(2, 32'h1234_5678);
      wr(1, 32'h1F);
      rd_chk("R3 locked write", 2, 0);
      rd_chk("R3 locked ctrl", 1, 0);
      @(negedge clk);
      chk("R3 still stopped", 32'(h_count), 0);
      rd_chk("R3 unmapped read", 12, 0);

      // R2 wrong key leaves lock closed, right key opens
      wr(0, 32'h1111_2222);
      rd_chk("R2 wrong key", 0, 0);
      wr(0, KEY);
      rd_chk("R2 unlocked", 0, 1);
      wr(0, 32'h0000_0007);
      rd_chk("R2 other value keeps open", 0, 1);

      // R4 field packing and readback
      program_all();
      rd_chk("R4 h act/total", 2, 32'h0009_0005);
      rd_chk("R4 v sync pair", 7, 32'h0005_0004);
      rd_chk("R4 panel v pair", 9, 32'h0004_0003);

      // R5..R10 full sweeps, several enable patterns
      sweep(5'b11111, 2);
      sweep(5'b00011, 1);
      sweep(5'b10001, 1);   // R8: blank enable clear
      sweep(5'b01101, 1);

      // R6 stop
      wr(1, 32'h1E);
      @(negedge clk);
      chk("R6 h park", 32'(h_count), 0);
      chk("R6 v park", 32'(v_count), 0);
      chk("R6 outputs low", 32'({de, hsync, vsync, pnl_hsync, pnl_vsync, pnl_de}), 0);
      repeat (5) @(negedge clk);
      chk("R6 stays parked", 32'(h_count), 0);

      // R2 relock, R3 writes ignored afterwards, raster unchanged
      wr(1, 32'h1F);
      wr(0, 32'd0);
      rd_chk("R2 relocked", 0, 0);
      wr(2, pack2(3, 4));
      wr(4, pack2(1, 2));
      wr(1, 32'd0);
      rd_chk("R3 relocked h pair", 2, 32'h0009_0005);
      rd_chk("R3 relocked ctrl", 1, 32'h1F);
      // sweep cannot rewrite ctrl while locked, so unlock with same timing
      wr(0, KEY);
      sweep(5'b11111, 1);

      // R9 second timing: different sync window
      HSS = 8; HSE = 10; VSS = 6; VSE = 7; PVS = 5; PVE = 6;
      program_all();
      sweep(5'b11111, 1);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule